// File: doc/BRIEF.md
# Remote Terminal Command Decoder

This block sits inside a remote terminal on a command/response serial bus, directly after the word receiver. Each validated 16-bit command word is checked against the terminal's strapped address and the broadcast address. The decoder then splits the word into its fields and issues a one-cycle action descriptor. The descriptor tells the rest of the terminal one of three things: that data words are about to arrive, that data must be sent, or that a mode command has to be handled.

During a receive, the decoder counts the data words the word receiver announces. When the message ends, it compares that number with the count it decoded. It also builds the 16-bit status reply and decides whether the reply goes out at all. Broadcasts are taken in silently. A count mismatch suppresses the reply and is reported in the next status word. Data buffering and the serial line codec are handled elsewhere.

Top module: `rt_cmd_decoder`

## Requirements
- R1: A command is acted on only when its address field equals `own_addr`, or equals 31 while `bcast_en` is 1. Any other command gives no action, no reply and no commit. It also leaves a receive in progress and the status flags unchanged.
- R2: Command word fields are: [15:11] address, [10] direction (1 = transmit, 0 = receive), [9:5] subaddress, [4:0] count or mode code. An accepted command raises `act_valid` for one cycle, on the cycle after `cmd_valid`. `act_kind` is encoded as 1 receive data, 2 transmit data, 3 mode without data word, 4 mode with a received data word, 5 mode with a transmitted data word. `act_subaddr` carries bits [9:5].
- R3: On data subaddresses `act_words` equals the count field, and a count field of 0 gives 32.
- R4: Subaddress 0 or 31 makes the command a mode command, and `act_mode` carries bits [4:0]. Mode codes 16 to 31 carry one data word, whose direction follows bit [10]. Mode codes 0 to 15 carry none, and `act_words` is then 0.
- R5: A non-broadcast transmit command, or a non-broadcast mode command without data, raises `stat_valid` on the cycle after the command.
- R6: A receive command (kind 1 or 4) raises `rx_open`. While it is open, each `data_valid` strobe is counted, including one in the same cycle as `msg_end`. On `msg_end` with a matching count, `rx_commit` pulses and `rx_open` falls on the next cycle. A non-broadcast status reply is sent in that same cycle.
- R7: On `msg_end` with a count mismatch there is no reply and no commit. Bit [10] (message error) is then set in the next status word sent.
- R8: A broadcast never produces a status reply. An accepted broadcast (a receive with a matching count, or a mode command without data) sets bit [4] in the next status word sent. A broadcast command that would require the terminal to transmit is ignored.
- R9: Message error and broadcast-received are cleared once a status word has been sent.
- R10: The status word layout is: [15:11] `own_addr`, [10] message error, [9] 0, [8] `svc_req`, [7:5] 0, [4] broadcast received, [3] `busy`, [2] `subsys_flag`, [1] `dyn_bus_acc`, [0] `term_flag`.
- R11: An accepted command during an open receive abandons that receive with no error, no reply and no commit. `data_valid` and `msg_end` have no effect while no receive is open.
- R12: After reset all outputs are 0 and both status flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 5 | Strapped terminal address |
| bcast_en | input | 1 | Accept broadcast commands |
| cmd_valid | input | 1 | Validated command word present |
| cmd_word | input | 16 | Command word |
| data_valid | input | 1 | One validated data word received |
| msg_end | input | 1 | End of the incoming message |
| svc_req | input | 1 | Service request status bit |
| busy | input | 1 | Busy status bit |
| subsys_flag | input | 1 | Subsystem flag status bit |
| dyn_bus_acc | input | 1 | Dynamic bus acceptance status bit |
| term_flag | input | 1 | Terminal flag status bit |
| act_valid | output | 1 | Action descriptor valid (one cycle) |
| act_kind | output | 3 | Action kind |
| act_subaddr | output | 5 | Decoded subaddress |
| act_words | output | 6 | Data words to move (0 to 32) |
| act_mode | output | 5 | Mode code number |
| act_bcast | output | 1 | Action came from a broadcast |
| rx_open | output | 1 | Data phase in progress |
| rx_commit | output | 1 | Received data count matched |
| stat_valid | output | 1 | Status word to be sent (one cycle) |
| stat_word | output | 16 | Status word |

## Verification
A stuck or stale message-error or broadcast-received flag shows up in the very next status word the terminal sends. That status word can be a full message after the event that set or should have cleared the flag. The bench therefore always follows error, broadcast and abandon scenarios with a transmit command and reads the status word it produces. A wrong word counter, or a data phase that fails to close, shows one cycle after `msg_end`: `rx_commit` or `stat_valid` takes the wrong value, or `rx_open` stays high. A wrong address match or a wrong direction decode shows on the cycle after `cmd_valid`, in `act_valid`, `act_kind` and `stat_valid`.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;

    localparam int ADDR_W     = 5;
    localparam int SUBA_W     = 5;
    localparam int CNT_W      = 5;
    localparam int WORD_W     = 1 + ADDR_W + SUBA_W + CNT_W;
    localparam int WCNT_W     = CNT_W + 1;
    localparam int MAX_WORDS  = 1 << CNT_W;
    localparam int BCAST_ADDR = (1 << ADDR_W) - 1;
    localparam int MODE_SUBA_HI = (1 << SUBA_W) - 1;
    localparam int RSVD_W     = WORD_W - ADDR_W - 8;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_RX      = 3'd1,
        ACT_TX      = 3'd2,
        ACT_MODE    = 3'd3,
        ACT_MODE_RX = 3'd4,
        ACT_MODE_TX = 3'd5
    } act_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              xmit;
        logic [SUBA_W-1:0] suba;
        logic [CNT_W-1:0]  cnt;
    } cmd_t;

    typedef struct packed {
        act_kind_e         kind;
        logic [WCNT_W-1:0] words;
        logic [SUBA_W-1:0] suba;
        logic [CNT_W-1:0]  mode;
        logic              bcast;
        logic              accept;
    } decode_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              msg_err;
        logic              instr;
        logic              svc_req;
        logic [RSVD_W-1:0] rsvd;
        logic              bcast_rcvd;
        logic              busy;
        logic              subsys;
        logic              dyn_bus;
        logic              term_flag;
    } status_t;

    function automatic logic is_mode_suba(input logic [SUBA_W-1:0] s);
        return (s == '0) || (s == SUBA_W'(MODE_SUBA_HI));
    endfunction

    function automatic logic [WCNT_W-1:0] words_of(input logic [CNT_W-1:0] c);
        return (c == '0) ? WCNT_W'(MAX_WORDS) : WCNT_W'(c);
    endfunction

    function automatic logic mode_has_data(input logic [CNT_W-1:0] code);
        return code[CNT_W-1];
    endfunction

    function automatic logic needs_transmit(input act_kind_e k);
        return (k == ACT_TX) || (k == ACT_MODE_TX);
    endfunction

    function automatic logic opens_rx(input act_kind_e k);
        return (k == ACT_RX) || (k == ACT_MODE_RX);
    endfunction

endpackage

// File: rtl/rt_cmd_field_decode.sv
module rt_cmd_field_decode
    import rt_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    output decode_t           dec
);
    cmd_t c;
    logic is_bc_addr;
    logic own_hit;
    logic bc_hit;

    always_comb begin
        c          = cmd_t'(cmd_word);
        is_bc_addr = (c.addr == ADDR_W'(BCAST_ADDR));
        own_hit    = !is_bc_addr && (c.addr == own_addr);
        bc_hit     = is_bc_addr && bcast_en;

        dec        = '0;
        dec.suba   = c.suba;
        dec.bcast  = bc_hit;

        if (is_mode_suba(c.suba)) begin
            dec.mode = c.cnt;
            if (!mode_has_data(c.cnt)) begin
                dec.kind  = ACT_MODE;
                dec.words = '0;
            end else begin
                dec.kind  = c.xmit ? ACT_MODE_TX : ACT_MODE_RX;
                dec.words = WCNT_W'(1);
            end
        end else begin
            dec.kind  = c.xmit ? ACT_TX : ACT_RX;
            dec.words = words_of(c.cnt);
        end

        dec.accept = own_hit || (bc_hit && !needs_transmit(dec.kind));
    end

endmodule

// File: rtl/rt_rx_word_counter.sv
module rt_rx_word_counter
    import rt_cmd_pkg::*;
#(
    parameter int SAT = MAX_WORDS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    output logic [WCNT_W-1:0] total
);
    logic [WCNT_W-1:0] cnt_q;

    always_comb begin
        if (inc && (cnt_q != WCNT_W'(SAT)))
            total = cnt_q + WCNT_W'(1);
        else
            total = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else
            cnt_q <= total;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WCNT_W'(SAT)); // R6

endmodule

// File: rtl/rt_status_reg.sv
module rt_status_reg
    import rt_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              svc_req,
    input  logic              busy,
    input  logic              subsys_flag,
    input  logic              dyn_bus_acc,
    input  logic              term_flag,
    input  logic              set_err,
    input  logic              set_bcr,
    input  logic              send,
    output status_t           st
);
    logic me_q;
    logic bcr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            me_q  <= 1'b0;
            bcr_q <= 1'b0;
        end else begin
            if (set_err)   me_q <= 1'b1;
            else if (send) me_q <= 1'b0;
            if (set_bcr)   bcr_q <= 1'b1;
            else if (send) bcr_q <= 1'b0;
        end
    end

    always_comb begin
        st            = '0;
        st.addr       = own_addr;
        st.msg_err    = me_q;
        st.instr      = 1'b0;
        st.svc_req    = svc_req;
        st.rsvd       = '0;
        st.bcast_rcvd = bcr_q;
        st.busy       = busy;
        st.subsys     = subsys_flag;
        st.dyn_bus    = dyn_bus_acc;
        st.term_flag  = term_flag;
    end

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        send |=> (!me_q && !bcr_q)); // R9

    AST_SET_NOT_WITH_SEND: assert property (@(posedge clk) disable iff (rst)
        !(send && (set_err || set_bcr))); // R7

endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
    import rt_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              data_valid,
    input  logic              msg_end,
    input  logic              svc_req,
    input  logic              busy,
    input  logic              subsys_flag,
    input  logic              dyn_bus_acc,
    input  logic              term_flag,
    output logic              act_valid,
    output logic [2:0]        act_kind,
    output logic [SUBA_W-1:0] act_subaddr,
    output logic [WCNT_W-1:0] act_words,
    output logic [CNT_W-1:0]  act_mode,
    output logic              act_bcast,
    output logic              rx_open,
    output logic              rx_commit,
    output logic              stat_valid,
    output logic [WORD_W-1:0] stat_word
);
    decode_t           dec;
    status_t           st;
    logic [WCNT_W-1:0] rx_total;
    logic [WCNT_W-1:0] exp_q;
    logic              bcast_q;
    act_kind_e         kind_q;

    logic take_cmd;
    logic end_rx;
    logic count_ok;
    logic imm_reply;
    logic rx_reply;
    logic send;
    logic set_err;
    logic set_bcr;
    logic cnt_inc;

    rt_cmd_field_decode u_decode (
        .cmd_word (cmd_word),
        .own_addr (own_addr),
        .bcast_en (bcast_en),
        .dec      (dec)
    );

    rt_rx_word_counter u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (take_cmd),
        .inc   (cnt_inc),
        .total (rx_total)
    );

    rt_status_reg u_status (
        .clk         (clk),
        .rst         (rst),
        .own_addr    (own_addr),
        .svc_req     (svc_req),
        .busy        (busy),
        .subsys_flag (subsys_flag),
        .dyn_bus_acc (dyn_bus_acc),
        .term_flag   (term_flag),
        .set_err     (set_err),
        .set_bcr     (set_bcr),
        .send        (send),
        .st          (st)
    );

    always_comb begin
        take_cmd  = cmd_valid && dec.accept;
        cnt_inc   = data_valid && rx_open && !take_cmd;
        end_rx    = rx_open && msg_end && !take_cmd;
        count_ok  = (rx_total == exp_q);
        imm_reply = take_cmd && !dec.bcast && !opens_rx(dec.kind);
        rx_reply  = end_rx && count_ok && !bcast_q;
        send      = imm_reply || rx_reply;
        set_err   = end_rx && !count_ok;
        set_bcr   = (take_cmd && dec.bcast && (dec.kind == ACT_MODE))
                 || (end_rx && count_ok && bcast_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_valid   <= 1'b0;
            kind_q      <= ACT_NONE;
            act_subaddr <= '0;
            act_words   <= '0;
            act_mode    <= '0;
            act_bcast   <= 1'b0;
            rx_open     <= 1'b0;
            rx_commit   <= 1'b0;
            stat_valid  <= 1'b0;
            stat_word   <= '0;
            exp_q       <= '0;
            bcast_q     <= 1'b0;
        end else begin
            act_valid  <= take_cmd;
            rx_commit  <= end_rx && count_ok;
            stat_valid <= send;
            if (send)
                stat_word <= WORD_W'(st);
            if (take_cmd) begin
                kind_q      <= dec.kind;
                act_subaddr <= dec.suba;
                act_words   <= dec.words;
                act_mode    <= dec.mode;
                act_bcast   <= dec.bcast;
                exp_q       <= dec.words;
                bcast_q     <= dec.bcast;
                rx_open     <= opens_rx(dec.kind);
            end else if (end_rx) begin
                rx_open     <= 1'b0;
            end
        end
    end

    assign act_kind = kind_q;

    AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_bcast) |-> !stat_valid); // R8

    AST_RX_OPEN_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_open) |-> (act_valid && opens_rx(kind_q))); // R6

    AST_NO_REPLY_IN_RX: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !rx_open); // R6

    AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        rx_commit |-> !rx_open); // R6

    AST_STAT_ADDR: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_word[WORD_W-1 -: ADDR_W] == $past(own_addr))); // R10

    AST_WORDS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (act_valid && (kind_q == ACT_RX || kind_q == ACT_TX))
        |-> (act_words >= WCNT_W'(1) && act_words <= WCNT_W'(MAX_WORDS))); // R3

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> (kind_q != ACT_NONE)); // R2

endmodule

// File: tb/rt_cmd_decoder_tb.sv
module rt_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] OWN = 5'd9;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  own_addr;
    logic        bcast_en;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        data_valid;
    logic        msg_end;
    logic        svc_req, busy, subsys_flag, dyn_bus_acc, term_flag;
    logic        act_valid;
    logic [2:0]  act_kind;
    logic [4:0]  act_subaddr;
    logic [5:0]  act_words;
    logic [4:0]  act_mode;
    logic        act_bcast;
    logic        rx_open;
    logic        rx_commit;
    logic        stat_valid;
    logic [15:0] stat_word;

    int total_checks = 0;
    int bad_checks   = 0;
    bit finished     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .own_addr(own_addr), .bcast_en(bcast_en),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .data_valid(data_valid),
        .msg_end(msg_end), .svc_req(svc_req), .busy(busy),
        .subsys_flag(subsys_flag), .dyn_bus_acc(dyn_bus_acc), .term_flag(term_flag),
        .act_valid(act_valid), .act_kind(act_kind), .act_subaddr(act_subaddr),
        .act_words(act_words), .act_mode(act_mode), .act_bcast(act_bcast),
        .rx_open(rx_open), .rx_commit(rx_commit), .stat_valid(stat_valid),
        .stat_word(stat_word)
    );

    typedef struct packed {
        logic [15:0] cmd;
        logic [5:0]  ndata;
        logic [2:0]  kind;
        logic [5:0]  words;
        logic        stat;
        logic        commit;
        logic        me;
        logic        bcr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{{5'd9,  1'b0, 5'd3,  5'd4},  6'd4,  3'd1, 6'd4,  1'b1, 1'b1, 1'b0, 1'b0},
        '{{5'd9,  1'b0, 5'd3,  5'd0},  6'd32, 3'd1, 6'd32, 1'b1, 1'b1, 1'b0, 1'b0},
        '{{5'd9,  1'b1, 5'd5,  5'd0},  6'd0,  3'd2, 6'd32, 1'b1, 1'b0, 1'b0, 1'b0},
        '{{5'd9,  1'b0, 5'd1,  5'd2},  6'd3,  3'd1, 6'd2,  1'b0, 1'b0, 1'b0, 1'b0},
        '{{5'd9,  1'b1, 5'd2,  5'd1},  6'd0,  3'd2, 6'd1,  1'b1, 1'b0, 1'b1, 1'b0},
        '{{5'd9,  1'b1, 5'd2,  5'd1},  6'd0,  3'd2, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0},
        '{{5'd31, 1'b0, 5'd4,  5'd2},  6'd2,  3'd1, 6'd2,  1'b0, 1'b1, 1'b0, 1'b0},
        '{{5'd9,  1'b1, 5'd0,  5'd2},  6'd0,  3'd3, 6'd0,  1'b1, 1'b0, 1'b0, 1'b1},
        '{{5'd9,  1'b1, 5'd31, 5'd1},  6'd0,  3'd3, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0},
        '{{5'd9,  1'b1, 5'd0,  5'd16}, 6'd0,  3'd5, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0},
        '{{5'd9,  1'b0, 5'd31, 5'd17}, 6'd1,  3'd4, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0},
        '{{5'd31, 1'b1, 5'd0,  5'd1},  6'd0,  3'd3, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0},
        '{{5'd31, 1'b0, 5'd0,  5'd20}, 6'd1,  3'd4, 6'd1,  1'b0, 1'b1, 1'b0, 1'b0},
        '{{5'd9,  1'b1, 5'd7,  5'd3},  6'd0,  3'd2, 6'd3,  1'b1, 1'b0, 1'b0, 1'b1},
        '{{5'd10, 1'b0, 5'd3,  5'd2},  6'd0,  3'd0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0},
        '{{5'd31, 1'b1, 5'd3,  5'd2},  6'd0,  3'd0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_status(input logic me, input logic bcr);
        return {OWN, me, 1'b0, svc_req, 3'b000, bcr, busy, subsys_flag, dyn_bus_acc, term_flag};
    endfunction

    task automatic send_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_data(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            data_valid = 1'b1;
        end
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic end_msg();
        @(negedge clk);
        msg_end = 1'b1;
        @(negedge clk);
        msg_end = 1'b0;
    endtask

    // transmit probe: status word after the command shows the flags
    task automatic probe_flags(input logic me, input logic bcr, input string req);
        send_cmd({OWN, 1'b1, 5'd2, 5'd1});
        check(stat_valid == 1'b1, req, stat_valid, 1);
        check(stat_word == exp_status(me, bcr), req, stat_word, exp_status(me, bcr));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; own_addr = OWN; bcast_en = 1'b1;
        cmd_valid = 1'b0; cmd_word = '0; data_valid = 1'b0; msg_end = 1'b0;
        svc_req = 1'b0; busy = 1'b0; subsys_flag = 1'b0; dyn_bus_acc = 1'b0; term_flag = 1'b0;
        repeat (3) @(negedge clk);

        // R12 reset state
        check({act_valid, act_kind, act_words, act_bcast, rx_open, rx_commit, stat_valid} == '0,
              "R12 outputs in reset", {act_valid, rx_open, stat_valid}, 0);
        check(stat_word == 16'h0, "R12 status word in reset", stat_word, 0);
        rst = 1'b0;
        @(negedge clk);
        probe_flags(1'b0, 1'b0, "R12 flags clear after reset");

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            send_cmd(t.cmd);
            check(act_valid == (t.kind != 3'd0), "R1 act_valid", act_valid, t.kind != 3'd0);
            if (t.kind != 3'd0) begin
                check(act_kind == t.kind, "R2 act_kind", act_kind, t.kind);
                check(act_subaddr == t.cmd[9:5], "R2 act_subaddr", act_subaddr, t.cmd[9:5]);
                check(act_words == t.words, "R3 act_words", act_words, t.words);
                check(act_bcast == (t.cmd[15:11] == 5'd31), "R8 act_bcast", act_bcast,
                      t.cmd[15:11] == 5'd31);
                if (t.kind >= 3'd3)
                    check(act_mode == t.cmd[4:0], "R4 act_mode", act_mode, t.cmd[4:0]);
            end
            if (t.kind == 3'd1 || t.kind == 3'd4) begin
                check(rx_open == 1'b1, "R6 rx_open after receive command", rx_open, 1);
                check(stat_valid == 1'b0, "R6 no reply at command", stat_valid, 0);
                if (t.ndata != 0) send_data(int'(t.ndata));
                end_msg();
                check(rx_commit == t.commit, "R6 R7 rx_commit", rx_commit, t.commit);
                check(stat_valid == t.stat, "R7 R8 stat_valid at end", stat_valid, t.stat);
                @(negedge clk);
                check(rx_open == 1'b0, "R6 rx_open closed", rx_open, 0);
            end else begin
                check(stat_valid == t.stat, "R5 R8 stat_valid at command", stat_valid, t.stat);
            end
            if (t.stat)
                check(stat_word == exp_status(t.me, t.bcr), "R9 R10 status word",
                      stat_word, exp_status(t.me, t.bcr));
            @(negedge clk);
        end

        // R10 status bit positions
        svc_req = 1'b1; busy = 1'b1; term_flag = 1'b1;
        probe_flags(1'b0, 1'b0, "R10 svc busy term bits");
        svc_req = 1'b0; busy = 1'b0; term_flag = 1'b0; subsys_flag = 1'b1; dyn_bus_acc = 1'b1;
        probe_flags(1'b0, 1'b0, "R10 subsys dynbus bits");
        subsys_flag = 1'b0; dyn_bus_acc = 1'b0;

        // R1 foreign command during an open receive is ignored
        send_cmd({OWN, 1'b0, 5'd6, 5'd2});
        send_data(1);
        send_cmd({5'd3, 1'b1, 5'd6, 5'd2});
        check(act_valid == 1'b0, "R1 foreign command no action", act_valid, 0);
        check(rx_open == 1'b1, "R1 receive kept open", rx_open, 1);
        send_data(1);
        end_msg();
        check(rx_commit == 1'b1, "R1 receive completes after foreign word", rx_commit, 1);
        check(stat_valid == 1'b1, "R1 reply after foreign word", stat_valid, 1);

        // R6 last data word in the same cycle as msg_end
        send_cmd({OWN, 1'b0, 5'd8, 5'd1});
        @(negedge clk);
        data_valid = 1'b1; msg_end = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; msg_end = 1'b0;
        check(rx_commit == 1'b1, "R6 word with msg_end counted", rx_commit, 1);

        // R11 abandon a receive with a new command
        send_cmd({OWN, 1'b0, 5'd8, 5'd3});
        send_data(1);
        send_cmd({OWN, 1'b1, 5'd8, 5'd3});
        check(stat_valid == 1'b1, "R11 new transmit replies", stat_valid, 1);
        check(rx_open == 1'b0, "R11 receive abandoned", rx_open, 0);
        end_msg();
        check(rx_commit == 1'b0 && stat_valid == 1'b0, "R11 msg_end after abandon",
              {rx_commit, stat_valid}, 0);
        probe_flags(1'b0, 1'b0, "R11 no error after abandon");

        // R11 stray data and msg_end while idle
        send_data(2);
        end_msg();
        check(rx_commit == 1'b0 && stat_valid == 1'b0, "R11 idle msg_end ignored",
              {rx_commit, stat_valid}, 0);
        probe_flags(1'b0, 1'b0, "R11 idle data leaves flags");

        // R1 broadcast disabled
        bcast_en = 1'b0;
        send_cmd({5'd31, 1'b0, 5'd4, 5'd2});
        check(act_valid == 1'b0 && rx_open == 1'b0, "R1 broadcast disabled ignored",
              {act_valid, rx_open}, 0);
        send_data(2);
        end_msg();
        probe_flags(1'b0, 1'b0, "R1 disabled broadcast sets no flag");
        bcast_en = 1'b1;

        // R8 broadcast count mismatch: error flag, no broadcast flag
        send_cmd({5'd31, 1'b0, 5'd4, 5'd3});
        send_data(1);
        end_msg();
        check(rx_commit == 1'b0 && stat_valid == 1'b0, "R8 broadcast mismatch silent",
              {rx_commit, stat_valid}, 0);
        probe_flags(1'b1, 1'b0, "R7 broadcast mismatch error flag");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule